// File: doc/BRIEF.md
# SPI Descriptor Chain Sequencer

This block lets an SPI controller run a whole message without software stepping through it. Software places a table of fixed 24-byte transfer descriptors in memory. It writes the table's base address into a pair of list-pointer registers, and the start is triggered by the top bit of the upper word. The sequencer then fetches each descriptor one 32-bit word at a time over a simple request/response read port. It checks the data-mode settings of the descriptor and hands the fields to the SPI shift engine. It waits for the engine to report completion, then moves on to the next descriptor, 24 bytes further on. It stops after the descriptor that carries the end-of-chain flag.

Completion and fault events are recorded in a sticky status register that software clears by writing ones. A separate enable register selects which status bits drive the interrupt line. A current-descriptor register pair shows where the walk is. A one-bit ownership flag lets several software agents share the controller: reading it returns its value and clears it, and writing 1 releases the controller again.

Top module: `sdc_chain_seq`

## Requirements
- R1: After reset the ownership flag reads 1, status (offset 0x30) and enable (offset 0x34) read 0, `irq` is low and `mem_req` is low.
- R2: A read of offset 0x00 returns the ownership flag and clears it, so a second read returns 0. A write to 0x00 loads the flag from write-data bit 0.
- R3: Writing offset 0x24 with bit 31 set starts a walk at the address {data[30:0], word at 0x20}. Descriptor words are fetched as 32-bit reads at ascending addresses, 4 bytes apart, and `mem_addr` is held until `mem_rvalid`.
- R4: Descriptor word 0 goes to `eng_start_cfg`, word 1 to `eng_bus_cfg`, words 2/3 (low/high) to `eng_tx_addr` and words 4/5 to `eng_rx_addr`. `eng_start` pulses for exactly one cycle with these fields valid.
- R5: After `eng_done`, status bit 10 is set. If bit 30 of word 0 is clear, the next descriptor is fetched from the current address + 24. If it is set, the walk stops and status bit 11 is set.
- R6: Offsets 0x28/0x2C read the low/high 32 bits of the address of the descriptor being executed, or of the last one executed.
- R7: An error response (`mem_rerr` with `mem_rvalid`) during a fetch sets status bits 8 and 2, ends the walk, and leaves bit 11 clear.
- R8: Word 0 bits 29:28 (transmit) and 27:26 (receive) select the data mode: 0 none, 1 register, 2 memory, 3 scatter-gather. Mode 2 or 3 with a zero 64-bit address for that direction makes the descriptor invalid. An invalid transmit side sets bit 1, an invalid receive side sets bit 5, and both set bit 8. An invalid descriptor is not launched and the walk stops.
- R9: Writing 1 to a status bit clears it; writing 0 leaves it unchanged.
- R10: `irq` is high exactly when some bit is set in both status and enable.
- R11: Writing 0 to offset 0x24 during a walk aborts it: no further `eng_start` or fetch occurs, and a later `eng_done` sets no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears ownership flag) |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | ADDR_W | Byte address of requested word |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| mem_rerr | input | 1 | Read response is an error |
| eng_start | output | 1 | One-cycle launch of the SPI engine |
| eng_start_cfg | output | 32 | Descriptor start-configuration word |
| eng_bus_cfg | output | 32 | Descriptor bus-configuration word |
| eng_tx_addr | output | 64 | Descriptor transmit address |
| eng_rx_addr | output | 64 | Descriptor receive address |
| eng_done | input | 1 | Engine finished the launched descriptor |

## Verification
Chains of one to four descriptors are swept against memory response latencies of 0 to 2 cycles and varied engine delays. This separates address stepping and end-of-chain detection from handshake timing. Fetch errors are injected at each of the six word positions of a second descriptor; this shows that the error stops the walk wherever it lands and that the first descriptor's completion is still reported. Every transmit and receive data mode is tried with a zero address, which tells the two invalid modes from the two harmless ones on each side. Abort, status clearing, enable masking and the ownership flag are tested with their own short sequences.

// File: rtl/sdc_pkg.sv
// Shared constants and types for the descriptor chain sequencer.
// Assumes 32-bit register and memory data words.
package sdc_pkg;
    localparam int STS_W         = 12;
    localparam int ST_RD_INVAL   = 1;
    localparam int ST_RD_RESP    = 2;
    localparam int ST_WR_INVAL   = 5;
    localparam int ST_DESC_ERR   = 8;
    localparam int ST_DESC_DONE  = 10;
    localparam int ST_CHAIN_DONE = 11;

    localparam int EOC_BIT = 30;
    localparam int TXM_LSB = 28;
    localparam int RXM_LSB = 26;

    localparam int DESC_WORDS = 6;
    localparam int DESC_BYTES = DESC_WORDS * 4;

    localparam logic [5:0] RA_SEM     = 6'h00;
    localparam logic [5:0] RA_LIST_LO = 6'h20;
    localparam logic [5:0] RA_LIST_HI = 6'h24;
    localparam logic [5:0] RA_CUR_LO  = 6'h28;
    localparam logic [5:0] RA_CUR_HI  = 6'h2C;
    localparam logic [5:0] RA_STS     = 6'h30;
    localparam logic [5:0] RA_IEN     = 6'h34;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_CHECK, S_LAUNCH, S_WAIT
    } seq_state_t;

    typedef enum logic [1:0] {
        DM_NONE, DM_REG, DM_MEM, DM_SG
    } dmode_t;
endpackage

// File: rtl/sdc_regs.sv
// Register file: ownership flag, list pointer, current pointer readback,
// sticky W1C status, interrupt enable and interrupt output.
// Assumes reg_rdata is sampled in the same cycle reg_rd is high.
module sdc_regs
    import sdc_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [5:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [STS_W-1:0]  sts_set,
    input  logic              busy,
    input  logic [ADDR_W-1:0] cur_addr,
    output logic              start_o,
    output logic              abort_o,
    output logic [ADDR_W-1:0] base_o,
    output logic              irq
);
    logic [31:0]      lo_q;
    logic [30:0]      hi_q;
    logic             sem_q;
    logic [STS_W-1:0] sts_q;
    logic [STS_W-1:0] ien_q;
    logic [63:0]      cur_wide;
    logic [STS_W-1:0] w1c;

    logic wr_hi, wr_sts;
    assign wr_hi  = reg_wr && (reg_addr == RA_LIST_HI);
    assign wr_sts = reg_wr && (reg_addr == RA_STS);

    // Start and abort commands decoded from the list-pointer high write.
    assign start_o = wr_hi && reg_wdata[31];
    assign abort_o = wr_hi && (reg_wdata == 32'd0);
    assign base_o  = ADDR_W'({reg_wdata[30:0], lo_q});

    assign cur_wide = 64'(cur_addr);
    assign w1c      = wr_sts ? reg_wdata[STS_W-1:0] : '0;
    assign irq      = |(sts_q & ien_q);

    // Register state updates; status sets win over same-cycle clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q  <= '0;
            hi_q  <= '0;
            sem_q <= 1'b1;
            sts_q <= '0;
            ien_q <= '0;
        end else begin
            if (reg_wr && reg_addr == RA_LIST_LO) lo_q <= reg_wdata;
            if (wr_hi) hi_q <= reg_wdata[30:0];
            if (reg_wr && reg_addr == RA_IEN) ien_q <= reg_wdata[STS_W-1:0];
            if (reg_wr && reg_addr == RA_SEM) sem_q <= reg_wdata[0];
            else if (reg_rd && reg_addr == RA_SEM) sem_q <= 1'b0;
            sts_q <= (sts_q & ~w1c) | sts_set;
        end
    end

    // Read data multiplexer.
    always_comb begin
        case (reg_addr)
            RA_SEM:     reg_rdata = {31'd0, sem_q};
            RA_LIST_LO: reg_rdata = lo_q;
            RA_LIST_HI: reg_rdata = {busy, hi_q};
            RA_CUR_LO:  reg_rdata = cur_wide[31:0];
            RA_CUR_HI:  reg_rdata = cur_wide[63:32];
            RA_STS:     reg_rdata = 32'(sts_q);
            RA_IEN:     reg_rdata = 32'(ien_q);
            default:    reg_rdata = 32'd0;
        endcase
    end

    // R2
    sem_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == RA_SEM && !reg_wr) |=> !sem_q);
    // R9
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && sts_set == '0) |=> ((sts_q & $past(reg_wdata[STS_W-1:0])) == '0));
endmodule

// File: rtl/sdc_seq.sv
// Descriptor walker: fetches six words per descriptor, validates the
// data-mode settings, launches the engine and follows the chain.
// Assumes one outstanding read; a response completes the current request.
module sdc_seq
    import sdc_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [ADDR_W-1:0] base,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_rerr,
    output logic              eng_start,
    output logic [31:0]       eng_start_cfg,
    output logic [31:0]       eng_bus_cfg,
    output logic [63:0]       eng_tx_addr,
    output logic [63:0]       eng_rx_addr,
    input  logic              eng_done,
    output logic              busy,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [STS_W-1:0]  sts_set
);
    localparam int WIDX_W = $clog2(DESC_WORDS);

    seq_state_t        state_q;
    logic [ADDR_W-1:0] cur_q;
    logic [WIDX_W-1:0] widx_q;
    logic [31:0]       dw_q [DESC_WORDS];
    logic [1:0]        bad;
    logic              eoc;

    assign eoc       = dw_q[0][EOC_BIT];
    assign busy      = (state_q != S_IDLE);
    assign cur_addr  = cur_q;
    assign mem_req   = (state_q == S_FETCH);
    assign mem_addr  = cur_q + ADDR_W'({widx_q, 2'b00});
    assign eng_start = (state_q == S_LAUNCH);

    assign eng_start_cfg = dw_q[0];
    assign eng_bus_cfg   = dw_q[1];
    assign eng_tx_addr   = {dw_q[3], dw_q[2]};
    assign eng_rx_addr   = {dw_q[5], dw_q[4]};

    // Per-direction validity: memory or scatter-gather modes need an address.
    for (genvar d = 0; d < 2; d++) begin : g_dir
        localparam int ML = (d == 0) ? TXM_LSB : RXM_LSB;
        localparam int AW = 2 + 2 * d;
        dmode_t mode;
        assign mode   = dmode_t'(dw_q[0][ML +: 2]);
        assign bad[d] = (mode == DM_MEM || mode == DM_SG) &&
                        ({dw_q[AW+1], dw_q[AW]} == 64'd0);
    end

    // Status event pulses handed to the register file.
    always_comb begin
        sts_set = '0;
        if (!abort) begin
            if (state_q == S_FETCH && mem_rvalid && mem_rerr) begin
                sts_set[ST_RD_RESP]  = 1'b1;
                sts_set[ST_DESC_ERR] = 1'b1;
            end
            if (state_q == S_CHECK && |bad) begin
                sts_set[ST_RD_INVAL] = bad[0];
                sts_set[ST_WR_INVAL] = bad[1];
                sts_set[ST_DESC_ERR] = 1'b1;
            end
            if (state_q == S_WAIT && eng_done) begin
                sts_set[ST_DESC_DONE]  = 1'b1;
                sts_set[ST_CHAIN_DONE] = eoc;
            end
        end
    end

    // Walk state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cur_q   <= '0;
            widx_q  <= '0;
            for (int i = 0; i < DESC_WORDS; i++) dw_q[i] <= '0;
        end else if (abort) begin
            state_q <= S_IDLE;
        end else begin
            case (state_q)
                S_IDLE: if (start) begin
                    cur_q   <= base;
                    widx_q  <= '0;
                    state_q <= S_FETCH;
                end
                S_FETCH: if (mem_rvalid) begin
                    if (mem_rerr) begin
                        state_q <= S_IDLE;
                    end else begin
                        dw_q[widx_q] <= mem_rdata;
                        if (widx_q == WIDX_W'(DESC_WORDS - 1)) state_q <= S_CHECK;
                        else widx_q <= widx_q + 1'b1;
                    end
                end
                S_CHECK:  state_q <= (|bad) ? S_IDLE : S_LAUNCH;
                S_LAUNCH: state_q <= S_WAIT;
                S_WAIT: if (eng_done) begin
                    if (eoc) begin
                        state_q <= S_IDLE;
                    end else begin
                        cur_q   <= cur_q + ADDR_W'(DESC_BYTES);
                        widx_q  <= '0;
                        state_q <= S_FETCH;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid && !abort) |=> (mem_req && $stable(mem_addr)));
    // R4
    launch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);
    // R5
    eoc_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && eng_done && eoc && !abort) |=> !busy);
    // R7
    fetch_err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_rvalid && mem_rerr && !abort) |=> (!busy && !mem_req));
    // R11
    abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!mem_req && !eng_start));
endmodule

// File: rtl/sdc_chain_seq.sv
// Top level: register file plus descriptor walker.
// Assumes ADDR_W between 33 and 63 so the list pointer fits.
module sdc_chain_seq
    import sdc_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [5:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_rerr,
    output logic              eng_start,
    output logic [31:0]       eng_start_cfg,
    output logic [31:0]       eng_bus_cfg,
    output logic [63:0]       eng_tx_addr,
    output logic [63:0]       eng_rx_addr,
    input  logic              eng_done
);
    logic              start, abort, busy;
    logic [ADDR_W-1:0] base, cur_addr;
    logic [STS_W-1:0]  sts_set;

    sdc_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sts_set(sts_set), .busy(busy), .cur_addr(cur_addr),
        .start_o(start), .abort_o(abort), .base_o(base), .irq(irq)
    );

    sdc_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .base(base),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .mem_rerr(mem_rerr), .eng_start(eng_start),
        .eng_start_cfg(eng_start_cfg), .eng_bus_cfg(eng_bus_cfg),
        .eng_tx_addr(eng_tx_addr), .eng_rx_addr(eng_rx_addr),
        .eng_done(eng_done), .busy(busy), .cur_addr(cur_addr), .sts_set(sts_set)
    );
endmodule

// File: tb/sdc_chain_seq_test.sv
// Self-checking bench: memory and engine models plus swept scenarios.
module sdc_chain_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 40;
    localparam logic [AW-1:0] BASE = 40'h05_0000_0100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        reg_wr = 0, reg_rd = 0;
    logic [5:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic        irq, mem_req, mem_rvalid = 0, mem_rerr = 0, eng_start, eng_done = 0;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_rdata = 0, eng_start_cfg, eng_bus_cfg;
    logic [63:0] eng_tx_addr, eng_rx_addr;

    sdc_chain_seq #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rerr(mem_rerr),
        .eng_start(eng_start), .eng_start_cfg(eng_start_cfg),
        .eng_bus_cfg(eng_bus_cfg), .eng_tx_addr(eng_tx_addr),
        .eng_rx_addr(eng_rx_addr), .eng_done(eng_done)
    );

    int checks = 0, fails = 0;
    logic [31:0] mem [0:31];
    int lat = 0, elat = 0, err_idx = -1;
    int wcnt = 0, rd_cnt = 0, addr_bad = 0, eng_cnt = 0, ecnt = 0;
    logic [31:0] log_s [0:7];
    logic [31:0] log_b [0:7];
    logic [63:0] log_t [0:7];
    logic [63:0] log_r [0:7];

    // Memory model: answers after lat idle cycles, logs address order.
    always @(negedge clk) begin
        if (mem_rvalid) begin
            mem_rvalid = 0; mem_rerr = 0; wcnt = 0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                if (mem_addr != BASE + AW'(4 * rd_cnt)) addr_bad++;
                mem_rdata  = mem[rd_cnt % 32];
                mem_rerr   = (rd_cnt == err_idx);
                mem_rvalid = 1;
                rd_cnt++;
            end else wcnt++;
        end else wcnt = 0;
    end

    // Engine model: logs launched fields, reports done after elat cycles.
    always @(negedge clk) begin
        eng_done = 0;
        if (eng_start) begin
            log_s[eng_cnt % 8] = eng_start_cfg;
            log_b[eng_cnt % 8] = eng_bus_cfg;
            log_t[eng_cnt % 8] = eng_tx_addr;
            log_r[eng_cnt % 8] = eng_rx_addr;
            eng_cnt++;
            ecnt = elat + 1;
        end else if (ecnt > 0) begin
            ecnt--;
            if (ecnt == 0) eng_done = 1;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rd_cnt = 0; addr_bad = 0; eng_cnt = 0; ecnt = 0; err_idx = -1;
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_addr = a; reg_rd = 1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    // Build n descriptors; txm/rxm modes, optional zero addresses.
    task automatic build(input int n, input int txm, input int rxm, input bit ztx, input bit zrx);
        for (int i = 0; i < n; i++) begin
            mem[6*i]   = ((i == n-1) ? 32'h4000_0000 : 0) | (32'(txm) << 28) | (32'(rxm) << 26) | 32'(i);
            mem[6*i+1] = 32'h0000_B000 + 32'(i);
            mem[6*i+2] = ztx ? 0 : 32'h2000 + 32'(16*i);
            mem[6*i+3] = ztx ? 0 : 32'(i);
            mem[6*i+4] = zrx ? 0 : 32'h3000 + 32'(i);
            mem[6*i+5] = 0;
        end
    endtask

    task automatic kick();
        wr(6'h20, BASE[31:0]);
        wr(6'h24, 32'h8000_0000 | 32'(BASE[AW-1:32]));
    endtask

    task automatic wait_irq(input string tag);
        int n = 0;
        while (!irq && n < 3000) begin @(negedge clk); n++; end
        check(irq, tag, 0, 1);
    endtask

    logic [31:0] v;

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check(!irq && !mem_req, "R1 irq/mem_req", {irq, mem_req}, 0);
        rd(6'h30, v); check(v == 0, "R1 status", v, 0);
        rd(6'h34, v); check(v == 0, "R1 enable", v, 0);
        // R2 ownership flag
        rd(6'h00, v); check(v == 1, "R2 first read", v, 1);
        rd(6'h00, v); check(v == 0, "R2 second read", v, 0);
        wr(6'h00, 1);
        rd(6'h00, v); check(v == 1, "R2 release", v, 1);

        // R3 R4 R5 R6 sweep: chain length x memory latency
        for (int n = 1; n <= 4; n++) begin
            for (int l = 0; l <= 2; l++) begin
                do_reset();
                lat = l; elat = n + l;
                build(n, 2, 3, 0, 0);
                wr(6'h34, 32'h926);
                kick();
                wait_irq("R5 chain irq");
                check(rd_cnt == 6*n && addr_bad == 0, "R3 fetch order", 64'(rd_cnt), 64'(6*n));
                check(eng_cnt == n, "R5 launches", 64'(eng_cnt), 64'(n));
                for (int i = 0; i < n && i < 8; i++) begin
                    check(log_s[i] == mem[6*i] && log_b[i] == mem[6*i+1], "R4 cfg words",
                          {log_s[i], log_b[i]}, {mem[6*i], mem[6*i+1]});
                    check(log_t[i] == {mem[6*i+3], mem[6*i+2]} && log_r[i] == {mem[6*i+5], mem[6*i+4]},
                          "R4 addresses", log_t[i], {mem[6*i+3], mem[6*i+2]});
                end
                rd(6'h30, v); check(v == 32'hC00, "R5 status", v, 32'hC00);
                rd(6'h28, v);
                check(v == 32'(BASE[31:0] + 32'(24*(n-1))), "R6 cur lo", v, BASE[31:0] + 32'(24*(n-1)));
                rd(6'h2C, v); check(v == 32'h5, "R6 cur hi", v, 5);
            end
        end

        // R7 fetch error at each word of descriptor 1
        for (int k = 0; k < 6; k++) begin
            do_reset();
            lat = 1; elat = 2;
            build(2, 2, 2, 0, 0);
            err_idx = 6 + k;
            wr(6'h34, 32'h926);
            kick();
            wait_irq("R7 err irq");
            repeat (5) @(negedge clk);
            check(eng_cnt == 1 && !mem_req, "R7 stop", 64'(eng_cnt), 1);
            rd(6'h30, v); check(v == 32'h504, "R7 status", v, 32'h504);
        end

        // R8 every mode on each side with zero address
        for (int side = 0; side < 2; side++) begin
            for (int m = 0; m < 4; m++) begin
                do_reset();
                lat = 0; elat = 1;
                if (side == 0) build(1, m, 0, 1, 0); else build(1, 0, m, 0, 1);
                wr(6'h34, 32'h926);
                kick();
                wait_irq("R8 irq");
                rd(6'h30, v);
                if (m >= 2) begin
                    check(v == ((side == 0) ? 32'h102 : 32'h120), "R8 invalid status", v,
                          (side == 0) ? 32'h102 : 32'h120);
                    check(eng_cnt == 0, "R8 not launched", 64'(eng_cnt), 0);
                end else begin
                    check(v == 32'hC00, "R8 valid status", v, 32'hC00);
                    check(eng_cnt == 1, "R8 launched", 64'(eng_cnt), 1);
                end
            end
        end

        // R10 R9 enable masking and write-one-to-clear
        do_reset();
        lat = 0; elat = 1;
        build(1, 1, 1, 0, 0);
        kick();
        repeat (60) @(negedge clk);
        check(!irq, "R10 masked", irq, 0);
        rd(6'h30, v); check(v == 32'hC00, "R10 status", v, 32'hC00);
        wr(6'h34, 32'h400); check(irq, "R10 enabled bit10", irq, 1);
        wr(6'h30, 32'h800); check(irq, "R9 other bit kept", irq, 1);
        rd(6'h30, v); check(v == 32'h400, "R9 partial clear", v, 32'h400);
        wr(6'h30, 32'h400);
        rd(6'h30, v); check(v == 0 && !irq, "R9 cleared", v, 0);

        // R11 abort during the first descriptor's execution
        do_reset();
        lat = 1; elat = 40;
        build(3, 2, 2, 0, 0);
        kick();
        while (eng_cnt == 0) @(negedge clk);
        wr(6'h24, 0);
        repeat (100) @(negedge clk);
        check(eng_cnt == 1 && !mem_req, "R11 halted", 64'(eng_cnt), 1);
        check(rd_cnt == 6, "R11 no fetch", 64'(rd_cnt), 6);
        rd(6'h30, v); check(v == 0, "R11 no status", v, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule